// File: doc/BRIEF.md
# Cell Receiver with Header Classification and Error Interrupt

This block sits behind a serial link receiver that already delivers 32-bit words. A receive-start indicator marks the first word of each fixed-length cell. The block frames the cell from the following words and decodes the header byte of that first word, which carries the type, the priority, a yellow marker and parity. Idle cells are dropped. The words of a data cell are sent on one by one through a valid/ready stream, with start and end markers and the priority.

The cell length is chosen per cell from 16 to 20 words. Every cell, idle or data, carries a CRC-16 that is checked against its last word. Header parity faults, reserved-bit faults, yellow cells and CRC faults raise a sticky interrupt when checking is enabled. The interrupt is cleared by a one-cycle pulse. The block holds no cell buffer. If the downstream side withholds ready, any input word that arrives in that time is lost, and a sticky overflow flag records the loss.

Top module: `cellrx_top`

## Requirements
- R1: After reset `out_valid`, `irq` and `ovf` are 0.
- R2: A cell is 16 + `len_sel` words long; a `len_sel` above 4 gives 20 words. The length is sampled with the first word of the cell. Words past the end of a cell that come without `rx_start` are not part of any cell.
- R3: The type, priority and markers are taken from the header byte, bits 31:24 of the first word. When bit 31 is 1 the cell is a data cell. Each of its words appears on `out_data` one cycle after it is taken in. `out_sop` is set on the first word only and `out_eop` on the last word only. `out_prio` equals header bits 30:29 for every word of the cell.
- R4: An idle cell (bit 31 = 0) produces no output word. An input word with `rx_valid` but without `rx_start`, arriving outside a cell, produces no output.
- R5: Header bit 27 must equal the XOR of bits 31:28. A mismatch is an error event.
- R6: A nonzero value in header bits 26:24 is an error event. Header bit 28 set (a yellow cell) is also an event, and a yellow data cell is still forwarded.
- R7: CRC-16 with polynomial 0x1021 and initial value 0xFFFF is computed most significant bit first over every word of a cell except the last. It is compared with bits 15:0 of the last word, for idle and data cells alike. A mismatch is an error event.
- R8: `irq` is sticky. It is set in the cycle after an event only if `chk_en` is 1 in the event's cycle, so events seen while `chk_en` is 0 never set it.
- R9: A one-cycle `irq_clr` pulse clears both `irq` and `ovf` in the next cycle. A new set in the same cycle takes precedence.
- R10: While `out_valid` is 1 and `out_ready` is 0, the output word and its markers hold. Any input word with `rx_valid` in such a cycle is not forwarded, and it sets the sticky `ovf` in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| len_sel | input | 3 | Cell length select, words = 16 + value, clamped at 20 |
| chk_en | input | 1 | Lets error events set the interrupt |
| irq_clr | input | 1 | One-cycle pulse that clears `irq` and `ovf` |
| rx_valid | input | 1 | Input word present |
| rx_start | input | 1 | Input word is the first word of a cell |
| rx_data | input | 32 | Input word |
| out_ready | input | 1 | Downstream accepts the output word |
| out_valid | output | 1 | Output word present |
| out_data | output | 32 | Output word |
| out_sop | output | 1 | First word of a data cell |
| out_eop | output | 1 | Last word of a data cell |
| out_prio | output | 2 | Priority of the cell being forwarded |
| irq | output | 1 | Sticky error interrupt |
| ovf | output | 1 | Sticky overflow flag |

## Verification
A framing counter that is off by one shows up within a single cell. The `out_eop` marker lands on the wrong word, the forwarded word count differs from 16 + `len_sel`, and the next cell's first word can be swallowed. A stale CRC register or a wrong seed raises `irq` on the cycle after the last word of a cell that is actually correct. A misread type or priority latch shows up on the second word of a data cell, through `out_prio` or through a missing word. The bench sweeps every length select against every priority. It also sends idle cells at each length, and it sends cells with faults of each kind injected.

// File: rtl/cellrx_pkg.sv
package cellrx_pkg;

   // Decoded header byte, most significant field first
   typedef struct packed {
      logic       is_data;
      logic [1:0] prio;
      logic       yellow;
      logic       par;
      logic [2:0] rsvd;
   } cell_hdr_t;

   localparam int HDR_W = 8;
   localparam int CRC_W = 16;
   localparam logic [CRC_W-1:0] CRC_POLY = 16'h1021;
   localparam logic [CRC_W-1:0] CRC_SEED = 16'hFFFF;

endpackage

// File: rtl/cellrx_frame.sv
module cellrx_frame #(
   parameter int MIN_WORDS = 16,
   parameter int MAX_WORDS = 20,
   parameter int LSEL_W    = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [LSEL_W-1:0] len_sel,
   input  logic              rx_valid,
   input  logic              rx_start,
   output logic              w_master,
   output logic              w_cont,
   output logic              w_last,
   output logic              w_take
);
   localparam int CNT_W = $clog2(MAX_WORDS + 1);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] len_q;
   logic [CNT_W-1:0] sel_words;
   logic             in_cell_q;

   generate
      if (MAX_WORDS == MIN_WORDS) begin : g_fixed
         logic unused_sel;
         assign unused_sel = ^len_sel;
         assign sel_words  = CNT_W'(MAX_WORDS);
      end else begin : g_prog
         localparam int SPAN = MAX_WORDS - MIN_WORDS;
         always_comb begin
            if (int'(len_sel) > SPAN)
               sel_words = CNT_W'(MAX_WORDS);
            else
               sel_words = CNT_W'(MIN_WORDS) + CNT_W'(len_sel);
         end
      end
   endgenerate

   assign w_master = rx_valid & rx_start;
   assign w_cont   = rx_valid & ~rx_start & in_cell_q;
   assign w_last   = w_cont & (cnt_q == (len_q - CNT_W'(1)));
   assign w_take   = w_master | w_cont;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q     <= '0;
         len_q     <= CNT_W'(MIN_WORDS);
         in_cell_q <= 1'b0;
      end else if (w_master) begin
         cnt_q     <= CNT_W'(1);
         len_q     <= sel_words;
         in_cell_q <= 1'b1;
      end else if (w_cont) begin
         cnt_q <= cnt_q + CNT_W'(1);
         if (w_last)
            in_cell_q <= 1'b0;
      end
   end

endmodule

// File: rtl/cellrx_hdr.sv
module cellrx_hdr
   import cellrx_pkg::*;
(
   input  logic [HDR_W-1:0] hdr_byte,
   output cell_hdr_t        hdr,
   output logic             par_err,
   output logic             rsvd_err
);
   assign hdr      = cell_hdr_t'(hdr_byte);
   assign par_err  = hdr.par != (hdr.is_data ^ hdr.prio[1] ^ hdr.prio[0] ^ hdr.yellow);
   assign rsvd_err = |hdr.rsvd;
endmodule

// File: rtl/cellrx_crc.sv
module cellrx_crc
   import cellrx_pkg::*;
#(
   parameter int WORD_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              w_master,
   input  logic              w_take,
   input  logic              w_last,
   input  logic [WORD_W-1:0] data,
   output logic              crc_err
);
   logic [CRC_W-1:0] crc_q;
   logic [CRC_W-1:0] crc_nxt;

   always_comb begin
      crc_nxt = w_master ? CRC_SEED : crc_q;
      for (int i = WORD_W - 1; i >= 0; i--) begin
         if (crc_nxt[CRC_W-1] ^ data[i])
            crc_nxt = {crc_nxt[CRC_W-2:0], 1'b0} ^ CRC_POLY;
         else
            crc_nxt = {crc_nxt[CRC_W-2:0], 1'b0};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         crc_q <= CRC_SEED;
      else if (w_take & ~w_last)
         crc_q <= crc_nxt;
   end

   assign crc_err = w_last & (crc_q != data[CRC_W-1:0]);
endmodule

// File: rtl/cellrx_top.sv
module cellrx_top
   import cellrx_pkg::*;
#(
   parameter int WORD_W    = 32,
   parameter int MIN_WORDS = 16,
   parameter int MAX_WORDS = 20,
   parameter int LSEL_W    = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [LSEL_W-1:0] len_sel,
   input  logic              chk_en,
   input  logic              irq_clr,
   input  logic              rx_valid,
   input  logic              rx_start,
   input  logic [WORD_W-1:0] rx_data,
   input  logic              out_ready,
   output logic              out_valid,
   output logic [WORD_W-1:0] out_data,
   output logic              out_sop,
   output logic              out_eop,
   output logic [1:0]        out_prio,
   output logic              irq,
   output logic              ovf
);
   generate
      if (WORD_W < CRC_W || WORD_W < HDR_W) begin : g_bad_width
         $error("cellrx_top: WORD_W too narrow for header and CRC");
      end
      if (MIN_WORDS < 2 || MAX_WORDS < MIN_WORDS) begin : g_bad_len
         $error("cellrx_top: cell length range invalid");
      end
      if ((1 << LSEL_W) <= (MAX_WORDS - MIN_WORDS)) begin : g_bad_sel
         $error("cellrx_top: LSEL_W cannot reach MAX_WORDS");
      end
   endgenerate

   logic      w_master, w_cont, w_last, w_take;
   cell_hdr_t hdr;
   logic      par_err, rsvd_err, crc_err;

   cellrx_frame #(
      .MIN_WORDS(MIN_WORDS), .MAX_WORDS(MAX_WORDS), .LSEL_W(LSEL_W)
   ) u_frame (
      .clk(clk), .rst_n(rst_n), .len_sel(len_sel),
      .rx_valid(rx_valid), .rx_start(rx_start),
      .w_master(w_master), .w_cont(w_cont), .w_last(w_last), .w_take(w_take)
   );

   cellrx_hdr u_hdr (
      .hdr_byte(rx_data[WORD_W-1 -: HDR_W]),
      .hdr(hdr), .par_err(par_err), .rsvd_err(rsvd_err)
   );

   cellrx_crc #(.WORD_W(WORD_W)) u_crc (
      .clk(clk), .rst_n(rst_n), .w_master(w_master), .w_take(w_take),
      .w_last(w_last), .data(rx_data), .crc_err(crc_err)
   );

   logic       is_data_q;
   logic [1:0] prio_q;
   logic       cur_data;
   logic [1:0] cur_prio;
   logic       stalled;
   logic       fwd;
   logic       evt;

   assign cur_data = w_master ? hdr.is_data : is_data_q;
   assign cur_prio = w_master ? hdr.prio : prio_q;
   assign stalled  = out_valid & ~out_ready;
   assign fwd      = w_take & cur_data & ~stalled;
   assign evt      = (w_master & (par_err | rsvd_err | hdr.yellow)) | crc_err;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         is_data_q <= 1'b0;
         prio_q    <= '0;
      end else if (w_master) begin
         is_data_q <= hdr.is_data;
         prio_q    <= hdr.prio;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_data  <= '0;
         out_sop   <= 1'b0;
         out_eop   <= 1'b0;
         out_prio  <= '0;
      end else if (fwd) begin
         out_valid <= 1'b1;
         out_data  <= rx_data;
         out_sop   <= w_master;
         out_eop   <= w_last;
         out_prio  <= cur_prio;
      end else if (out_ready) begin
         out_valid <= 1'b0;
         out_sop   <= 1'b0;
         out_eop   <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         irq <= 1'b0;
      else if (chk_en & evt)
         irq <= 1'b1;
      else if (irq_clr)
         irq <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ovf <= 1'b0;
      else if (rx_valid & stalled)
         ovf <= 1'b1;
      else if (irq_clr)
         ovf <= 1'b0;
   end

endmodule

// File: rtl/cellrx_chk.sv
module cellrx_chk #(
   parameter int WORD_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              chk_en,
   input logic              irq_clr,
   input logic              rx_valid,
   input logic              rx_start,
   input logic [WORD_W-1:0] rx_data,
   input logic              out_ready,
   input logic              out_valid,
   input logic [WORD_W-1:0] out_data,
   input logic              out_sop,
   input logic              out_eop,
   input logic              irq,
   input logic              ovf
);
   // R10
   stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_sop) && $stable(out_eop));

   // R10
   ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid && out_valid && !out_ready |=> ovf);

   // R8
   irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq && !irq_clr |=> irq);

   // R8
   irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !irq && !chk_en |=> !irq);

   // R9
   irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_clr && !chk_en |=> !irq);

   // R9
   ovf_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_clr && !(rx_valid && out_valid && !out_ready) |=> !ovf);

   // R3
   marker_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> !out_sop && !out_eop);

   // R4
   idle_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid && rx_start && !rx_data[WORD_W-1] && !(out_valid && !out_ready) |=> !out_valid);
endmodule

bind cellrx_top cellrx_chk #(.WORD_W(WORD_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .chk_en(chk_en), .irq_clr(irq_clr),
   .rx_valid(rx_valid), .rx_start(rx_start), .rx_data(rx_data),
   .out_ready(out_ready), .out_valid(out_valid), .out_data(out_data),
   .out_sop(out_sop), .out_eop(out_eop), .irq(irq), .ovf(ovf)
);

// File: tb/tb_cellrx_top.sv
module tb_cellrx_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  len_sel = '0;
   logic        chk_en = 1'b1;
   logic        irq_clr = 1'b0;
   logic        rx_valid = 1'b0;
   logic        rx_start = 1'b0;
   logic [31:0] rx_data = '0;
   logic        out_ready = 1'b1;
   logic        out_valid, out_sop, out_eop, irq, ovf;
   logic [31:0] out_data;
   logic [1:0]  out_prio;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #5 clk = ~clk;

   cellrx_top dut (
      .clk(clk), .rst_n(rst_n), .len_sel(len_sel), .chk_en(chk_en),
      .irq_clr(irq_clr), .rx_valid(rx_valid), .rx_start(rx_start),
      .rx_data(rx_data), .out_ready(out_ready), .out_valid(out_valid),
      .out_data(out_data), .out_sop(out_sop), .out_eop(out_eop),
      .out_prio(out_prio), .irq(irq), .ovf(ovf)
   );

   // capture of accepted output words
   logic [31:0] cap_d [0:2047];
   logic        cap_s [0:2047];
   logic        cap_e [0:2047];
   logic [1:0]  cap_p [0:2047];
   int          ncap = 0;

   always @(negedge clk) begin
      if (rst_n && out_valid && out_ready) begin
         cap_d[ncap & 2047] = out_data;
         cap_s[ncap & 2047] = out_sop;
         cap_e[ncap & 2047] = out_eop;
         cap_p[ncap & 2047] = out_prio;
         ncap = ncap + 1;
      end
   end

   logic [31:0] cw [0:31];

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [15:0] crc_word(input logic [15:0] c, input logic [31:0] w);
      logic [15:0] r = c;
      for (int b = 31; b >= 0; b--) begin
         logic top = r[15] ^ w[b];
         r = {r[14:0], 1'b0};
         if (top) r = r ^ 16'h1021;
      end
      return r;
   endfunction

   // builds n words in cw: header flags, parity flip, reserved bits, crc flip
   task automatic build(input int n, input bit t, input logic [1:0] p, input bit y,
                        input bit pflip, input logic [2:0] rs, input bit cflip, input int seed);
      logic [7:0]  h;
      logic [15:0] c;
      h = {t, p, y, (t ^ p[1] ^ p[0] ^ y ^ pflip), rs};
      cw[0] = {h, 24'(seed * 7919 + 3)};
      for (int i = 1; i < n; i++) cw[i] = 32'(seed) * 32'h9E3779B1 + 32'(i) * 32'h01010101;
      c = 16'hFFFF;
      for (int i = 0; i < n - 1; i++) c = crc_word(c, cw[i]);
      cw[n-1] = {cw[n-1][31:16], c ^ {15'd0, cflip}};
   endtask

   task automatic send(input int n);
      for (int i = 0; i < n; i++) begin
         rx_valid = 1'b1;
         rx_start = (i == 0);
         rx_data  = cw[i];
         @(posedge clk); #2;
      end
      rx_valid = 1'b0;
      rx_start = 1'b0;
   endtask

   task automatic settle();
      repeat (3) @(posedge clk);
      #2;
   endtask

   task automatic clear_pulse();
      irq_clr = 1'b1;
      @(posedge clk); #2;
      irq_clr = 1'b0;
   endtask

   task automatic check_fwd(input int base, input int n, input logic [1:0] p, input string req);
      bit ok = (ncap - base) == n;
      check(ok, {req, " word count"}, 32'(ncap - base), 32'(n));
      if (ok) begin
         bit good = 1;
         for (int i = 0; i < n; i++) begin
            int k = (base + i) & 2047;
            if (cap_d[k] !== cw[i] || cap_s[k] !== (i == 0) || cap_e[k] !== (i == n - 1) || cap_p[k] !== p)
               good = 0;
         end
         check(good, "R3 data/markers/prio", cap_d[base & 2047], cw[0]);
      end
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      int base;
      repeat (3) @(posedge clk);
      #2 rst_n = 1'b1;
      // R1
      check(out_valid == 0 && irq == 0 && ovf == 0, "R1 reset state",
            {29'd0, out_valid, irq, ovf}, 32'd0);
      @(posedge clk); #2;

      // R2 R3: every length select against every priority
      for (int ls = 0; ls < 5; ls++) begin
         for (int p = 0; p < 4; p++) begin
            len_sel = 3'(ls);
            build(16 + ls, 1, 2'(p), 0, 0, 3'd0, 0, ls * 4 + p + 1);
            base = ncap;
            send(16 + ls);
            settle();
            check_fwd(base, 16 + ls, 2'(p), "R2");
         end
      end
      // R8: clean cells raise nothing
      check(irq == 0, "R8 no event no irq", {31'd0, irq}, 32'd0);

      // R4 R7: idle cells with good CRC at each length
      for (int ls = 0; ls < 5; ls++) begin
         len_sel = 3'(ls);
         build(16 + ls, 0, 2'(ls), 0, 0, 3'd0, 0, 100 + ls);
         base = ncap;
         send(16 + ls);
         settle();
         check(ncap == base, "R4 idle cell dropped", 32'(ncap - base), 32'd0);
         check(irq == 0, "R7 idle good crc", {31'd0, irq}, 32'd0);
      end

      // R2 clamp: selects above 4 give 20 words
      for (int ls = 5; ls < 8; ls++) begin
         len_sel = 3'(ls);
         build(20, 1, 2'd2, 0, 0, 3'd0, 0, 200 + ls);
         base = ncap;
         send(20);
         settle();
         check_fwd(base, 20, 2'd2, "R2 clamp");
      end

      // R4: stray word after a 16-word cell is ignored
      len_sel = 3'd0;
      build(17, 1, 2'd1, 0, 0, 3'd0, 0, 300);
      build(16, 1, 2'd1, 0, 0, 3'd0, 0, 300);
      base = ncap;
      send(16);
      rx_valid = 1'b1; rx_start = 1'b0; rx_data = 32'hDEAD_BEEF;
      @(posedge clk); #2;
      rx_valid = 1'b0;
      settle();
      check(ncap - base == 16, "R4 stray word ignored", 32'(ncap - base), 32'd16);
      check(irq == 0, "R4 stray word no event", {31'd0, irq}, 32'd0);

      // R5: parity fault
      build(16, 1, 2'd3, 0, 1, 3'd0, 0, 400);
      send(16); settle();
      check(irq == 1, "R5 parity fault sets irq", {31'd0, irq}, 32'd1);
      clear_pulse();
      check(irq == 0, "R9 clear irq", {31'd0, irq}, 32'd0);

      // R6: reserved bits on an idle cell
      build(16, 0, 2'd0, 0, 0, 3'd5, 0, 401);
      send(16); settle();
      check(irq == 1, "R6 reserved bits set irq", {31'd0, irq}, 32'd1);
      clear_pulse();

      // R6: yellow data cell, still forwarded
      build(16, 1, 2'd2, 1, 0, 3'd0, 0, 402);
      base = ncap;
      send(16); settle();
      check(irq == 1, "R6 yellow sets irq", {31'd0, irq}, 32'd1);
      check(ncap - base == 16, "R6 yellow forwarded", 32'(ncap - base), 32'd16);
      clear_pulse();

      // R7: CRC fault on idle and on data cells
      build(18, 0, 2'd0, 0, 0, 3'd0, 1, 403);
      len_sel = 3'd2;
      send(18); settle();
      check(irq == 1, "R7 idle crc fault", {31'd0, irq}, 32'd1);
      clear_pulse();
      build(18, 1, 2'd1, 0, 0, 3'd0, 1, 404);
      send(18); settle();
      check(irq == 1, "R7 data crc fault", {31'd0, irq}, 32'd1);
      clear_pulse();

      // R8: checking disabled
      chk_en = 1'b0;
      build(18, 1, 2'd1, 0, 1, 3'd0, 1, 405);
      send(18); settle();
      check(irq == 0, "R8 disabled no irq", {31'd0, irq}, 32'd0);
      chk_en = 1'b1;

      // R10: stall while a data cell arrives
      len_sel = 3'd0;
      out_ready = 1'b0;
      build(16, 1, 2'd3, 0, 0, 3'd0, 0, 500);
      base = ncap;
      send(16); settle();
      check(ovf == 1, "R10 overflow set", {31'd0, ovf}, 32'd1);
      check(out_valid == 1 && out_data == cw[0] && out_sop == 1, "R10 output held", out_data, cw[0]);
      out_ready = 1'b1;
      settle();
      check(ncap - base == 1, "R10 dropped words", 32'(ncap - base), 32'd1);
      check(irq == 0, "R10 overflow not an irq", {31'd0, irq}, 32'd0);
      clear_pulse();
      check(ovf == 0, "R9 clear ovf", {31'd0, ovf}, 32'd0);

      // recovery after stall
      build(17, 1, 2'd0, 0, 0, 3'd0, 0, 501);
      len_sel = 3'd1;
      base = ncap;
      send(17); settle();
      check_fwd(base, 17, 2'd0, "R2 after stall");

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule